// File: doc/BRIEF.md
# Wake-Up Timer and Core Clock Divider

This block holds back the core clock after a start or wake event until the oscillator can be treated as stable. The hold-off has two parts. The first is a fixed number of oscillator cycles, and that number depends on the kind of source selected. The second is a settling time measured in ticks of a one-microsecond strobe. When both parts have elapsed, the block raises a ready flag. It then produces a core-clock enable at a rate chosen by an 8-bit divide setting, and a peripheral-clock enable at half the core rate. Both enables are single-cycle qualifiers on the oscillator clock; no clock is gated physically.

Software can rewrite the divide setting at any time. The divider picks up the new value only when the current core period closes, so no period is ever cut short. A low-power flag can be written by software but only holds 1 while the active divide gives a core rate no higher than a parameterised limit (8 MHz by default for a 14.746 MHz oscillator).

Top module: `clkctl_wake_div`

## Requirements
- R1: During and right after reset, clk_ready, core_en, periph_en and lowpwr are all 0, and the block waits idle until the first wake_req.
- R2: wake_req sampled high with src_sel equal to 0, 1 or 2 (crystal sources) starts a 992-cycle count. With us_tick held high, clk_ready rises exactly 1052 cycles after the edge that sampled wake_req.
- R3: wake_req sampled high with src_sel equal to any of 3 to 7 (RC, watchdog, external and unused codes) starts a 224-cycle count. With us_tick held high, clk_ready rises exactly 284 cycles after the sampling edge.
- R4: After the cycle count runs out, clk_ready rises on the edge that samples the 60th us_tick high. Ticks seen during the cycle count are not counted.
- R5: While clk_ready is 0, core_en and periph_en stay 0.
- R6: wake_req clears clk_ready on the next edge and restarts the full delay, even in the middle of a sequence. The source type is latched from src_sel on the edge that samples wake_req.
- R7: With divide value 0, core_en is high on every running cycle. With value N (1 to 255), core_en is one cycle high every 2N cycles. The first pulse falls in the first cycle that clk_ready is high.
- R8: A new div_cfg value takes effect only when the current core period ends. Every period in progress runs its full old length.
- R9: periph_en is high on the 1st, 3rd, 5th and later odd core_en pulses counted from the start of running, and low at all other times.
- R10: lp_we writes lp_wdata into lowpwr. A write of 1 is ignored when the active divide gives OSC_KHZ/div above LP_MAX_KHZ (div = 1 for value 0, else 2N).
- R11: lowpwr is forced to 0 whenever the active divide (the value in use, which follows div_cfg while not running) is too fast by the R10 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Clock source type code |
| wake_req | input | 1 | Start/wake request, one cycle |
| us_tick | input | 1 | One-microsecond strobe |
| div_cfg | input | 8 | Divide setting from software |
| lp_we | input | 1 | Low-power flag write strobe |
| lp_wdata | input | 1 | Low-power flag write value |
| core_en | output | 1 | Core-clock enable |
| periph_en | output | 1 | Peripheral-clock enable |
| clk_ready | output | 1 | Wake-up delay complete |
| lowpwr | output | 1 | Low-power flag |

## Verification
The assertions assume that wake_req is a synchronous pulse and that us_tick and div_cfg may change on any cycle, including in the middle of a sequence. The bench keeps all of these inputs on the clock by driving them only at the falling edge. It picks tick periods, source codes, divide values and low-power writes at random, so restarts, mid-period divide changes and rejected flag writes all occur. Directed runs with the tick held high pin down the exact latencies for both source classes.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_COUNT  = 2'd1,
      WK_SETTLE = 2'd2,
      WK_RUN    = 2'd3
   } wk_state_t;
endpackage

// File: rtl/clkctl_wake_timer.sv
module clkctl_wake_timer
   import clkctl_pkg::*;
#(
   parameter int SEL_W        = 3,
   parameter int XTAL_CODES   = 3,
   parameter int XTAL_CYC     = 992,
   parameter int OTHER_CYC    = 224,
   parameter int SETTLE_TICKS = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] src_sel,
   input  logic             wake_req,
   input  logic             us_tick,
   output logic             ready
);
   localparam int MAX_CYC   = (XTAL_CYC > OTHER_CYC) ? XTAL_CYC : OTHER_CYC;
   localparam int CNT_W     = $clog2(MAX_CYC + 1);
   localparam int TCK_W     = $clog2(SETTLE_TICKS + 1);
   localparam logic [CNT_W-1:0] XTAL_LAST  = CNT_W'(XTAL_CYC - 1);
   localparam logic [CNT_W-1:0] OTHER_LAST = CNT_W'(OTHER_CYC - 1);
   localparam logic [TCK_W-1:0] TICK_LAST  = TCK_W'(SETTLE_TICKS - 1);

   generate
      if (XTAL_CYC < 1 || OTHER_CYC < 1) begin : g_bad_cyc
         $error("wake cycle counts must be at least 1");
      end
      if (SETTLE_TICKS < 1) begin : g_bad_tick
         $error("settle tick count must be at least 1");
      end
      if (XTAL_CODES < 0 || XTAL_CODES > (1 << SEL_W)) begin : g_bad_codes
         $error("crystal code count out of range");
      end
   endgenerate

   wk_state_t        state;
   logic [CNT_W-1:0] cyc_cnt;
   logic [TCK_W-1:0] tick_cnt;
   logic             long_sel;
   logic [CNT_W-1:0] cyc_last;

   assign cyc_last = long_sel ? XTAL_LAST : OTHER_LAST;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= WK_IDLE;
         cyc_cnt  <= '0;
         tick_cnt <= '0;
         long_sel <= 1'b0;
      end else if (wake_req) begin
         state    <= WK_COUNT;
         cyc_cnt  <= '0;
         tick_cnt <= '0;
         long_sel <= (int'(src_sel) < XTAL_CODES);
      end else begin
         case (state)
            WK_COUNT: begin
               if (cyc_cnt == cyc_last) begin
                  state    <= WK_SETTLE;
                  tick_cnt <= '0;
               end else begin
                  cyc_cnt <= cyc_cnt + 1'b1;
               end
            end
            WK_SETTLE: begin
               if (us_tick) begin
                  if (tick_cnt == TICK_LAST) state <= WK_RUN;
                  else tick_cnt <= tick_cnt + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign ready = (state == WK_RUN);

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WK_COUNT) |-> (cyc_cnt <= cyc_last));
   p_wake_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !ready);
   p_settle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WK_SETTLE && !us_tick && !wake_req) |=> (state == WK_SETTLE));
   p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !wake_req) |=> ready);
endmodule

// File: rtl/clkctl_divider.sv
module clkctl_divider #(
   parameter int DIV_W    = 8,
   parameter int PCLK_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_cfg,
   output logic [DIV_W-1:0] div_act,
   output logic             core_en,
   output logic             periph_en
);
   localparam int LIM_W = DIV_W + 1;
   localparam int PH_W  = (PCLK_DIV > 1) ? $clog2(PCLK_DIV) : 1;

   generate
      if (DIV_W < 1) begin : g_bad_w
         $error("divide width must be at least 1");
      end
      if (PCLK_DIV < 1) begin : g_bad_p
         $error("peripheral ratio must be at least 1");
      end
   endgenerate

   logic [LIM_W-1:0] dcnt;
   logic [LIM_W-1:0] lim_act;

   always_comb begin
      if (div_act == '0) lim_act = '0;
      else               lim_act = {div_act, 1'b0} - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt    <= '0;
         div_act <= '0;
      end else if (!run) begin
         dcnt    <= '0;
         div_act <= div_cfg;
      end else if (dcnt == lim_act) begin
         dcnt    <= '0;
         div_act <= div_cfg;
      end else begin
         dcnt <= dcnt + 1'b1;
      end
   end

   assign core_en = run && (dcnt == '0);

   generate
      if (PCLK_DIV == 1) begin : g_pclk_same
         assign periph_en = core_en;
      end else begin : g_pclk_div
         logic [PH_W-1:0] ph_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ph_cnt <= '0;
            else if (!run)     ph_cnt <= '0;
            else if (core_en) begin
               if (ph_cnt == PH_W'(PCLK_DIV - 1)) ph_cnt <= '0;
               else                               ph_cnt <= ph_cnt + 1'b1;
            end
         end
         assign periph_en = core_en && (ph_cnt == '0);
      end
   endgenerate

   p_periph_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
      periph_en |-> core_en);
   p_no_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (core_en && div_act != '0 && run) |=> !core_en);
   p_run_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !core_en);
   p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !core_en) |-> $stable(div_act));
endmodule

// File: rtl/clkctl_lp_flag.sv
module clkctl_lp_flag #(
   parameter int DIV_W      = 8,
   parameter int OSC_KHZ    = 14746,
   parameter int LP_MAX_KHZ = 8000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_act,
   input  logic             lp_we,
   input  logic             lp_wdata,
   output logic             lowpwr
);
   generate
      if (OSC_KHZ < 1 || LP_MAX_KHZ < 1) begin : g_bad_f
         $error("frequencies must be positive");
      end
   endgenerate

   logic slow_ok;

   always_comb begin
      int unsigned ratio;
      ratio   = (div_act == '0) ? 1 : 2 * int'(div_act);
      slow_ok = (OSC_KHZ <= LP_MAX_KHZ * ratio);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lowpwr <= 1'b0;
      else if (!slow_ok) lowpwr <= 1'b0;
      else if (lp_we)   lowpwr <= lp_wdata;
   end

   p_lp_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_we && !lp_wdata) |=> !lowpwr);
   p_lp_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lowpwr) |-> $past(lp_we && lp_wdata));
endmodule

// File: rtl/clkctl_wake_div.sv
module clkctl_wake_div #(
   parameter int SEL_W        = 3,
   parameter int XTAL_CODES   = 3,
   parameter int XTAL_CYC     = 992,
   parameter int OTHER_CYC    = 224,
   parameter int SETTLE_TICKS = 60,
   parameter int DIV_W        = 8,
   parameter int PCLK_DIV     = 2,
   parameter int OSC_KHZ      = 14746,
   parameter int LP_MAX_KHZ   = 8000
) (
   input  logic             clk_osc,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] src_sel,
   input  logic             wake_req,
   input  logic             us_tick,
   input  logic [DIV_W-1:0] div_cfg,
   input  logic             lp_we,
   input  logic             lp_wdata,
   output logic             core_en,
   output logic             periph_en,
   output logic             clk_ready,
   output logic             lowpwr
);
   logic [DIV_W-1:0] div_act;

   clkctl_wake_timer #(
      .SEL_W(SEL_W), .XTAL_CODES(XTAL_CODES), .XTAL_CYC(XTAL_CYC),
      .OTHER_CYC(OTHER_CYC), .SETTLE_TICKS(SETTLE_TICKS)
   ) u_timer (
      .clk(clk_osc), .rst_n(rst_n), .src_sel(src_sel),
      .wake_req(wake_req), .us_tick(us_tick), .ready(clk_ready)
   );

   clkctl_divider #(.DIV_W(DIV_W), .PCLK_DIV(PCLK_DIV)) u_div (
      .clk(clk_osc), .rst_n(rst_n), .run(clk_ready), .div_cfg(div_cfg),
      .div_act(div_act), .core_en(core_en), .periph_en(periph_en)
   );

   clkctl_lp_flag #(.DIV_W(DIV_W), .OSC_KHZ(OSC_KHZ), .LP_MAX_KHZ(LP_MAX_KHZ)) u_lp (
      .clk(clk_osc), .rst_n(rst_n), .div_act(div_act),
      .lp_we(lp_we), .lp_wdata(lp_wdata), .lowpwr(lowpwr)
   );

   p_blocked_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
      !clk_ready |-> (!core_en && !periph_en));
   p_first_pulse_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
      $rose(clk_ready) |-> (core_en && periph_en));
endmodule

// File: tb/clkctl_wake_div_tb_top.sv
module clkctl_wake_div_tb_top;
   localparam int OSC = 14746;
   localparam int LPM = 8000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] src_sel = '0;
   logic wake_req = 1'b0;
   logic us_tick = 1'b0;
   logic [7:0] div_cfg = '0;
   logic lp_we = 1'b0;
   logic lp_wdata = 1'b0;
   logic core_en, periph_en, clk_ready, lowpwr;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int tick_per = 0;

   always #4 clk = ~clk;

   clkctl_wake_div #(.OSC_KHZ(OSC), .LP_MAX_KHZ(LPM)) dut_i (
      .clk_osc(clk), .rst_n(rst_n), .src_sel(src_sel), .wake_req(wake_req),
      .us_tick(us_tick), .div_cfg(div_cfg), .lp_we(lp_we), .lp_wdata(lp_wdata),
      .core_en(core_en), .periph_en(periph_en), .clk_ready(clk_ready),
      .lowpwr(lowpwr)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic int m_lim(input int d);
      return (d == 0) ? 0 : 2 * d - 1;
   endfunction
   function automatic bit m_slow(input int d);
      return (d == 0) ? (OSC <= LPM) : (OSC <= LPM * 2 * d);
   endfunction

   // reference model from the requirements
   int m_st = 0, m_c = 0, m_t = 0, m_long = 0;
   int m_da = 0, m_dc = 0, m_ph = 0, m_lp = 0;
   int m_run, m_core;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_st = 0; m_c = 0; m_t = 0; m_long = 0;
         m_da = 0; m_dc = 0; m_ph = 0; m_lp = 0;
      end else begin
         m_run  = (m_st == 3) ? 1 : 0;
         m_core = (m_run == 1 && m_dc == 0) ? 1 : 0;
         if (!m_slow(m_da)) m_lp = 0;
         else if (lp_we)    m_lp = int'(lp_wdata);
         if (m_run == 0) begin
            m_dc = 0; m_da = int'(div_cfg); m_ph = 0;
         end else begin
            if (m_core == 1) m_ph = 1 - m_ph;
            if (m_dc == m_lim(m_da)) begin m_dc = 0; m_da = int'(div_cfg); end
            else m_dc++;
         end
         if (wake_req) begin
            m_st = 1; m_c = 0; m_t = 0; m_long = (src_sel < 3) ? 1 : 0;
         end else if (m_st == 1) begin
            if (m_c == ((m_long == 1) ? 992 : 224) - 1) begin m_st = 2; m_t = 0; end
            else m_c++;
         end else if (m_st == 2 && us_tick) begin
            if (m_t == 59) m_st = 3;
            else m_t++;
         end
      end
   end

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         int er, ec;
         er = (m_st == 3) ? 1 : 0;
         ec = (er == 1 && m_dc == 0) ? 1 : 0;
         chk("R4 clk_ready", int'(clk_ready), er);
         chk("R7 R8 core_en", int'(core_en), ec);
         chk("R9 periph_en", int'(periph_en), (ec == 1 && m_ph == 0) ? 1 : 0);
         chk("R10 R11 lowpwr", int'(lowpwr), m_lp);
         if (!clk_ready) chk("R5 core blocked", int'(core_en | periph_en), 0);
      end
   end

   // tick generator, driven at the falling edge
   always @(negedge clk) begin
      if (tick_per == 0) us_tick <= 1'b1;
      else               us_tick <= (($urandom % tick_per) == 0);
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wake(input int sel);
      @(negedge clk);
      src_sel  = 3'(sel);
      wake_req = 1'b1;
      @(negedge clk);
      wake_req = 1'b0;
   endtask

   // measure edges from the wake sampling edge to the first ready cycle
   task automatic wake_latency(input int sel, output int lat);
      @(negedge clk);
      src_sel  = 3'(sel);
      wake_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wake_req = 1'b0;
      lat = 0;
      while (!clk_ready && lat < 5000) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic lp_write(input bit v);
      @(negedge clk);
      lp_we = 1'b1; lp_wdata = v;
      @(negedge clk);
      lp_we = 1'b0;
   endtask

   initial begin
      int lat;
      int pulses, prev, gap_bad;
      void'($urandom(32'h5eed_c10c));
      tick_per = 0;
      idle(3);
      chk("R1 reset ready",  int'(clk_ready), 0);
      chk("R1 reset core",   int'(core_en),   0);
      chk("R1 reset periph", int'(periph_en), 0);
      chk("R1 reset lowpwr", int'(lowpwr),    0);
      rst_n = 1'b1;
      idle(20);
      chk("R1 idle until wake", int'(clk_ready), 0);

      // directed: crystal and other latencies with tick held high
      wake_latency(1, lat);
      chk("R2 crystal latency", lat, 1052);
      wake_latency(4, lat);
      chk("R3 other latency", lat, 284);
      wake_latency(7, lat);
      chk("R3 unused code latency", lat, 284);

      // R6: restart mid-sequence from crystal to RC
      wake(0);
      idle(500);
      wake_latency(3, lat);
      chk("R6 restart latency", lat, 284);

      // R7: divide 0 and divide 3 pulse trains
      div_cfg = 8'd0;
      wake_latency(5, lat);
      pulses = 0;
      for (int i = 0; i < 12; i++) begin
         pulses += int'(core_en);
         @(negedge clk);
      end
      chk("R7 div0 pulses", pulses, 12);
      div_cfg = 8'd3;
      idle(4);
      pulses = 0;
      for (int i = 0; i < 60; i++) begin
         pulses += int'(core_en);
         @(negedge clk);
      end
      chk("R7 div3 pulses in 60", pulses, 10);

      // R8: change mid-period, gaps must be old or new length only
      div_cfg = 8'd5;
      prev = -1; gap_bad = 0;
      for (int i = 0; i < 80; i++) begin
         if (core_en) begin
            if (prev >= 0 && (i - prev) != 6 && (i - prev) != 10) gap_bad++;
            prev = i;
         end
         @(negedge clk);
      end
      chk("R8 period lengths", gap_bad, 0);

      // R10 / R11: low-power flag rules
      div_cfg = 8'd0;
      idle(20);
      lp_write(1'b1);
      idle(1);
      chk("R10 write rejected when fast", int'(lowpwr), 0);
      div_cfg = 8'd1;
      idle(10);
      lp_write(1'b1);
      idle(1);
      chk("R10 write accepted when slow", int'(lowpwr), 1);
      div_cfg = 8'd0;
      idle(10);
      chk("R11 auto clear when fast", int'(lowpwr), 0);

      // random phase
      for (int it = 0; it < 16; it++) begin
         tick_per = int'($urandom % 4);
         div_cfg  = ($urandom % 8 == 0) ? 8'd255 : 8'($urandom % 7);
         wake(int'($urandom % 8));
         for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            if ($urandom % 50 == 0) div_cfg = 8'($urandom % 9);
            if ($urandom % 40 == 0) begin lp_we = 1'b1; lp_wdata = 1'($urandom); end
            else lp_we = 1'b0;
            if ($urandom % 1200 == 0) begin
               src_sel = 3'($urandom); wake_req = 1'b1;
            end else wake_req = 1'b0;
         end
         lp_we = 1'b0; wake_req = 1'b0;
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule